// File: doc/BRIEF.md
# Soft-Start Duty Ramp Sequencer

This block produces the switch duty that a lamp channel applies while the lamp is being brought up. A start pulse begins a fixed ramp of sixteen lamp cycles. The ramp is described by four configuration bytes. Each byte holds two 3-bit duty codes, and each code covers two consecutive lamp cycles. For each cycle the sequencer presents a duty in whole percent. It raises a hold flag when the code asks to keep the last applied duty. It raises a done flag once the ramp is finished.

A downstream pulse-width generator consumes the duty value. A lamp-cycle tick from the channel's oscillator moves the ramp forward. The configuration bytes are read live from a flat input bus. The block does no shadowing or storage of them.

Top module: `ss_ramp_seq`

## Requirements
- R1: While reset is asserted, and after it until the first start, `duty_pct_o` is 0, `hold_o` is 0 and `done_o` is 0.
- R2: The clock edge that samples `start_i` high makes lamp cycle 1 current from the next clock cycle. Each later `tick_i` sampled during a run advances to the next lamp cycle. A tick sampled outside a run changes no output.
- R3: Lamp cycle k (1..16) takes its code from configuration byte floor((k-1)/4), where byte n occupies `cfg_i[8n+7:8n]`. Within a byte, bits 2:0 serve the first two of its four cycles and bits 6:4 serve the last two.
- R4: Each code stays in force for exactly two lamp cycles, however many clock cycles lie between ticks.
- R5: Codes 0,1,2,3,4,5,6 give duties of 0,3,6,9,13,16,19 percent with `hold_o` low.
- R6: Code 7 drives `hold_o` high and keeps `duty_pct_o` at the duty of the most recent lamp cycle of the current run that had a fixed code.
- R7: If code 7 is in force before any fixed code has been applied in the current run, the duty is 0 percent.
- R8: Bits 3 and 7 of every configuration byte have no effect on any output.
- R9: The tick that ends lamp cycle 16 sets `done_o` from the next clock cycle. `done_o` stays set until the next start. While it is set, `hold_o` is 0 and `duty_pct_o` keeps the effective duty of cycle 16.
- R10: A start during a run, or together with a tick, restarts at lamp cycle 1. It clears `done_o` and forgets the previously applied duty.
- R11: With configuration bytes 21h, 43h, 65h, 77h (byte 0 first), the ramp over cycles 1..16 is 3,3,6,6,9,9,13,13,16,16,19,19, followed by four cycles of 19 with `hold_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin (or restart) the ramp |
| tick_i | input | 1 | One-clock pulse per lamp cycle |
| cfg_i | input | 32 | Four configuration bytes, byte 0 in bits 7:0 |
| duty_pct_o | output | 5 | Duty for the current lamp cycle, in percent |
| hold_o | output | 1 | Current code asks to keep the last duty |
| done_o | output | 1 | Ramp finished |

## Verification
On every cycle the assertions check the following. The cycle index steps by one per accepted tick and restarts at one after a start. `done_o` never overlaps a run and never shows with `hold_o`. A fixed-code duty is always one of the seven legal values. A held duty equals the previous cycle's duty, or zero straight after a start. The assertions cannot see the mapping from byte and nibble position to lamp cycle, the two-cycle span of each code, or the blindness to reserved bits. Those are shown only by the bench scenarios, which compare the full ramp for several configurations, irregular tick spacing, reserved bits set, idle ticks and a mid-run restart.

// File: rtl/ss_ramp_pkg.sv
package ss_ramp_pkg;
  localparam int CODE_W = 3;
  localparam int DUTY_W = 5;
  localparam int BYTE_W = 8;
  localparam logic [CODE_W-1:0] CODE_KEEP = 3'd7;

  function automatic logic [DUTY_W-1:0] code_to_pct(input logic [CODE_W-1:0] code);
    logic [DUTY_W-1:0] pct;
    case (code)
      3'd0:    pct = 5'd0;
      3'd1:    pct = 5'd3;
      3'd2:    pct = 5'd6;
      3'd3:    pct = 5'd9;
      3'd4:    pct = 5'd13;
      3'd5:    pct = 5'd16;
      3'd6:    pct = 5'd19;
      default: pct = 5'd0;
    endcase
    return pct;
  endfunction
endpackage

// File: rtl/ss_cycle_ctr.sv
module ss_cycle_ctr #(
  parameter int NUM_CYCLES = 16,
  localparam int IDX_W = $clog2(NUM_CYCLES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             active_o,
  output logic             done_o,
  output logic             adv_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CYCLES - 1);

  logic [IDX_W-1:0] idx_q;
  logic             active_q, done_q;
  logic             last_c;

  assign adv_o  = tick_i & active_q & ~start_i;
  assign last_c = (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (start_i) begin
      idx_q    <= '0;
      active_q <= 1'b1;
      done_q   <= 1'b0;
    end else if (adv_o) begin
      if (last_c) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign idx_o    = idx_q;
  assign active_o = active_q;
  assign done_o   = done_q;

  // R10
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (active_o && idx_o == '0 && !done_o));
  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && idx_o != LAST_IDX) |=> (active_o && idx_o == $past(idx_o) + 1'b1));
  // R9
  finish_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && idx_o == LAST_IDX) |=> (done_o && !active_o));
  // R9
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && active_o));
  // R2
  idle_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !start_i) |=> (!active_o && $stable(done_o)));
endmodule

// File: rtl/ss_code_sel.sv
module ss_code_sel
  import ss_ramp_pkg::*;
#(
  parameter int NUM_BYTES       = 4,
  parameter int CYCLES_PER_CODE = 2,
  localparam int CODES_PER_BYTE = 2,
  localparam int NUM_CODES      = NUM_BYTES * CODES_PER_BYTE,
  localparam int NUM_CYCLES     = NUM_CODES * CYCLES_PER_CODE,
  localparam int IDX_W          = $clog2(NUM_CYCLES),
  localparam int SEL_W          = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1
) (
  input  logic [NUM_BYTES*BYTE_W-1:0] cfg_i,
  input  logic [IDX_W-1:0]            idx_i,
  output logic [CODE_W-1:0]           code_o
);
  logic [CODE_W-1:0] codes [NUM_CODES];
  logic [IDX_W-1:0]  slot;

  // bits 3 and 7 of each byte are never tapped
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    assign codes[b*CODES_PER_BYTE]     = cfg_i[b*BYTE_W     +: CODE_W];
    assign codes[b*CODES_PER_BYTE + 1] = cfg_i[b*BYTE_W + 4 +: CODE_W];
  end

  assign slot   = idx_i / IDX_W'(CYCLES_PER_CODE);
  assign code_o = codes[slot[SEL_W-1:0]];
endmodule

// File: rtl/ss_duty_hold.sv
module ss_duty_hold
  import ss_ramp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              adv_i,
  input  logic              active_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              hold_o
);
  logic [DUTY_W-1:0] held_q;
  logic              fixed_c;

  assign fixed_c = active_i && (code_i != CODE_KEEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 held_q <= '0;
    else if (start_i)            held_q <= '0;
    else if (adv_i && fixed_c)   held_q <= code_to_pct(code_i);
  end

  assign hold_o = active_i && (code_i == CODE_KEEP);
  assign duty_o = fixed_c ? code_to_pct(code_i) : held_q;

  // R5
  duty_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fixed_c |-> (duty_o inside {5'd0, 5'd3, 5'd6, 5'd9, 5'd13, 5'd16, 5'd19}));
  // R6
  keep_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && $past(active_i) && !$past(start_i)) |-> (duty_o == $past(duty_o)));
  // R7
  keep_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && $past(start_i)) |-> (duty_o == '0));
endmodule

// File: rtl/ss_ramp_seq.sv
module ss_ramp_seq
  import ss_ramp_pkg::*;
#(
  parameter int NUM_BYTES       = 4,
  parameter int CYCLES_PER_CODE = 2,
  localparam int NUM_CYCLES     = NUM_BYTES * 2 * CYCLES_PER_CODE,
  localparam int IDX_W          = $clog2(NUM_CYCLES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        tick_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] cfg_i,
  output logic [DUTY_W-1:0]           duty_pct_o,
  output logic                        hold_o,
  output logic                        done_o
);
  logic [IDX_W-1:0]  idx;
  logic              active, adv;
  logic [CODE_W-1:0] code;

  ss_cycle_ctr #(.NUM_CYCLES(NUM_CYCLES)) u_ctr (
    .clk_i, .rst_ni, .start_i, .tick_i,
    .idx_o(idx), .active_o(active), .done_o(done_o), .adv_o(adv)
  );

  ss_code_sel #(.NUM_BYTES(NUM_BYTES), .CYCLES_PER_CODE(CYCLES_PER_CODE)) u_sel (
    .cfg_i, .idx_i(idx), .code_o(code)
  );

  ss_duty_hold u_duty (
    .clk_i, .rst_ni, .start_i, .adv_i(adv), .active_i(active),
    .code_i(code), .duty_o(duty_pct_o), .hold_o(hold_o)
  );

  // R9
  done_no_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !hold_o);
endmodule

// File: tb/ss_ramp_seq_bench.sv
`timescale 1ns/1ps
module ss_ramp_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        tick_i = 1'b0;
  logic [31:0] cfg_i = 32'h0;
  logic [4:0]  duty_pct_o;
  logic        hold_o, done_o;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  ss_ramp_seq u_ss_ramp_seq (.*);

  // reference state, from the requirements
  bit       m_active = 0, m_done = 0;
  int       m_idx = 0;
  int       m_held = 0;

  int    exp_duty_q[$];
  bit    exp_hold_q[$];
  bit    exp_done_q[$];
  string exp_req_q[$];

  function automatic int pct_of(input int c);
    int tbl [7] = '{0, 3, 6, 9, 13, 16, 19};
    return tbl[c];
  endfunction

  function automatic int code_at(input int k);
    logic [7:0] b;
    b = cfg_i[(k/4)*8 +: 8];
    return ((k % 4) < 2) ? int'(b[2:0]) : int'(b[6:4]);
  endfunction

  task automatic check(input string req, input int a_d, input int e_d,
                       input bit a_h, input bit e_h, input bit a_n, input bit e_n);
    n_run++;
    if (a_d != e_d || a_h != e_h || a_n != e_n) begin
      n_fail++;
      $display("FAIL %s: duty/hold/done actual %0d/%0d/%0d expected %0d/%0d/%0d",
               req, a_d, a_h, a_n, e_d, e_h, e_n);
    end
  endtask

  // driver: drive at negedge, push what the next edge must produce
  task automatic step(input bit s, input bit t, input string req);
    int c;
    @(negedge clk_i);
    start_i = s;
    tick_i  = t;
    if (s) begin
      m_active = 1; m_idx = 0; m_held = 0; m_done = 0;
    end else if (t && m_active) begin
      c = code_at(m_idx);
      if (c != 7) m_held = pct_of(c);
      if (m_idx == 15) begin m_active = 0; m_done = 1; end
      else m_idx++;
    end
    if (m_active) begin
      c = code_at(m_idx);
      exp_duty_q.push_back(c == 7 ? m_held : pct_of(c));
      exp_hold_q.push_back(c == 7);
    end else begin
      exp_duty_q.push_back(m_held);
      exp_hold_q.push_back(1'b0);
    end
    exp_done_q.push_back(m_done);
    exp_req_q.push_back(req);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (exp_duty_q.size() > 0)
      check(exp_req_q.pop_front(), duty_pct_o, exp_duty_q.pop_front(),
            hold_o, exp_hold_q.pop_front(), done_o, exp_done_q.pop_front());
  end

  task automatic expect_now(input string req, input int d, input bit h, input bit n);
    @(posedge clk_i); #1.5;
    check(req, duty_pct_o, d, hold_o, h, done_o, n);
  endtask

  task automatic full_run(input string req, input int gap);
    step(1, 0, req);
    for (int k = 0; k < 16; k++) begin
      for (int g = 0; g < (k + gap) % 3 * gap; g++) step(0, 0, req);
      step(0, 1, req);
    end
    step(0, 0, req);
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int ramp [16] = '{3,3,6,6,9,9,13,13,16,16,19,19,19,19,19,19};
    #12;
    check("R1 in reset", duty_pct_o, 0, hold_o, 0, done_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    // R2: ticks before any start are ignored
    cfg_i = 32'h7765_4321;
    step(0, 1, "R2 idle tick");
    step(0, 1, "R1 R2 idle tick");
    step(0, 0, "R1 after reset");

    // R11: default bytes, checked against a fixed table
    step(1, 0, "R11 start");
    for (int k = 0; k < 16; k++) begin
      expect_now("R11 ramp", ramp[k], k >= 12, 0);
      step(0, 1, "R11 R3 R5 R6 ramp");
    end
    expect_now("R11 R9 done", 19, 0, 1);

    // R9: ticks after done change nothing
    step(0, 1, "R9 tick after done");
    step(0, 1, "R9 tick after done");
    step(0, 0, "R9 hold done");

    // R3 R4 R8: mixed codes, reserved bits set, irregular gaps
    cfg_i = 32'h0F5A_3B12;
    full_run("R3 R4 R8 mixed", 1);
    full_run("R4 wide gaps", 2);

    // R7: code 7 before any fixed duty
    cfg_i = 32'h7136_06F7;
    step(1, 0, "R7 start");
    expect_now("R7 first keep", 0, 1, 0);
    full_run("R7 R6 keep", 0);

    // R8: only reserved bits set -> all zero duty
    cfg_i = 32'h8888_8888;
    step(1, 0, "R8 start");
    for (int k = 0; k < 16; k++) begin
      expect_now("R8 reserved", 0, 0, 0);
      step(0, 1, "R8 reserved ramp");
    end

    // R10: restart mid-run, also together with a tick
    cfg_i = 32'h7765_4321;
    step(1, 0, "R10 start");
    for (int k = 0; k < 5; k++) step(0, 1, "R10 advance");
    step(1, 1, "R10 restart with tick");
    expect_now("R10 back to cycle 1", 3, 0, 0);
    full_run("R10 after restart", 0);
    cfg_i = 32'h6677_7777;
    step(1, 0, "R10 R7 forget held");
    expect_now("R10 R7 held cleared", 0, 1, 0);
    step(0, 0, "R10 idle");

    repeat (3) @(posedge clk_i);
    #2;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule